// File: doc/BRIEF.md
# Comparator Trigger Status Register with Live and Sticky Views

This block reports eight comparator trigger inputs through one 32-bit status word on a simple register bus with address, read strobe, write strobe and write data. A mode input picks what the word shows. In live view a read returns the trigger levels at that moment. In sticky view each bit is a flag. A trigger's rising edge sets its flag, and software clears the flag by writing a one to that bit position.

An enable input gates every write. A clear is accepted only in sticky view and only while this enable is high. The flags track trigger edges all the time, including in live view, and whether or not a trigger is used as a fault source elsewhere. Switching to sticky view therefore shows the history collected so far, and software normally clears the flags after it changes the view. Read data is registered and is valid one cycle after the read strobe.

Top module: `trig_fault_status`

## Requirements
- R1: After reset all eight flags are 0, and the read data output is 0.
- R2: Bits 31 down to 8 of every read are 0. Trigger n (n = 0..7) is reported in bit n.
- R3: With the view input at 0 (live), a read at the register address returns each trigger's level in the cycle of the read strobe.
- R4: With the view input at 0, writes to the register address clear no flag.
- R5: A rising edge of a trigger sets its flag. The edge is the trigger at 1 in a cycle where it was 0 in the previous cycle, and a trigger at 1 in the first cycle after reset also counts as an edge. The flag stays 1 after the trigger returns to 0.
- R6: With the view input at 1 (sticky) and the enable at 1, a write clears every flag whose write data bit is 1. Flags whose write data bit is 0 keep their value. A read in sticky view returns the flags.
- R7: With the enable input at 0, writes clear no flag.
- R8: If a rising edge and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R9: Flags are set by trigger edges while the view input is 0. A later read in sticky view shows them.
- R10: A read at any other address returns 0, and a write at any other address changes no flag.
- R11: Read data appears in the cycle after the read strobe. In any cycle that does not follow a read strobe at the register address, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| view_sticky | input | 1 | 0 = live trigger levels, 1 = sticky flags with write-one-to-clear |
| clr_enable | input | 1 | Gates all clearing writes |
| trig_in | input | 8 | Comparator trigger levels, already synchronous to clk |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; a 1 selects a flag to clear |
| bus_rdata | output | 32 | Registered read data |

## Verification
Setting a flag and clearing it are the two actions that can land on the same flag in the same cycle. The bench sets two flags and lets their triggers fall. It then raises one trigger again in the same cycle as a write that clears both flags. The read-back must show the re-triggered flag still at 1 and its neighbour at 0. This shows that the write took effect and that the set won only where the two collided.

// File: rtl/trig_stat_pkg.sv
package trig_stat_pkg;
  typedef enum logic {
    VIEW_LIVE   = 1'b0,
    VIEW_STICKY = 1'b1
  } view_e;

  function automatic view_e to_view(input logic sel);
    return sel ? VIEW_STICKY : VIEW_LIVE;
  endfunction
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] trig,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= trig;
  end

  assign rise = trig & ~prev_q;

  // R5: an edge cannot be seen two cycles running on the same input
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chk
      a_r5_no_double_edge: assert property (@(posedge clk) disable iff (rst)
        rise[g] |=> !rise[g]);
    end
  endgenerate
endmodule

// File: rtl/trig_sticky_bank.sv
module trig_sticky_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic flag_q;

      always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (rise[g]) flag_q <= 1'b1;
        else if (clr[g])  flag_q <= 1'b0;
      end

      assign flags[g] = flag_q;

      a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr[g]) |=> flag_q);
      a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        rise[g] |=> flag_q);
      a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr[g] && !rise[g]) |=> !flag_q);
    end
  endgenerate
endmodule

// File: rtl/trig_bus_port.sv
module trig_bus_port
  import trig_stat_pkg::*;
#(
  parameter int          N        = 8,
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter logic [AW-1:0] REG_ADDR = 8'h08
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          view_sticky,
  input  logic          clr_enable,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  live,
  input  logic [N-1:0]  flags,
  output logic [N-1:0]  clr,
  output logic [DW-1:0] rdata
);
  localparam int PAD = DW - N;

  view_e        view;
  logic         hit;
  logic [N-1:0] shown;
  logic [DW-1:0] rdata_q;

  assign view  = to_view(view_sticky);
  assign hit   = (addr == REG_ADDR);
  assign shown = (view == VIEW_STICKY) ? flags : live;

  always_comb begin
    clr = '0;
    if (wr && hit && clr_enable && view == VIEW_STICKY)
      clr = wdata[N-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)            rdata_q <= '0;
    else if (rd && hit) rdata_q <= {{PAD{1'b0}}, shown};
    else                rdata_q <= '0;
  end

  assign rdata = rdata_q;

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[DW-1:N] == '0);
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && !hit) |=> rdata == '0);
  a_r3_live_view: assert property (@(posedge clk) disable iff (rst)
    (rd && hit && !view_sticky) |=> rdata[N-1:0] == $past(live));
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0);
endmodule

// File: rtl/trig_fault_status.sv
module trig_fault_status #(
  parameter int            N        = 8,
  parameter int            AW       = 8,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] REG_ADDR = 8'h08
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          view_sticky,
  input  logic          clr_enable,
  input  logic [N-1:0]  trig_in,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  logic [N-1:0] rise;
  logic [N-1:0] clr;
  logic [N-1:0] flags;

  trig_edge_det #(.N(N)) u_edge (
    .clk (clk),
    .rst (rst),
    .trig(trig_in),
    .rise(rise)
  );

  trig_sticky_bank #(.N(N)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .rise (rise),
    .clr  (clr),
    .flags(flags)
  );

  trig_bus_port #(.N(N), .AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_port (
    .clk        (clk),
    .rst        (rst),
    .view_sticky(view_sticky),
    .clr_enable (clr_enable),
    .addr       (bus_addr),
    .rd         (bus_rd),
    .wr         (bus_wr),
    .wdata      (bus_wdata),
    .live       (trig_in),
    .flags      (flags),
    .clr        (clr),
    .rdata      (bus_rdata)
  );

  a_r4_live_no_clear: assert property (@(posedge clk) disable iff (rst)
    !view_sticky |=> ($past(flags) & ~flags) == '0);
  a_r7_gate_no_clear: assert property (@(posedge clk) disable iff (rst)
    !clr_enable |=> ($past(flags) & ~flags) == '0);
  a_r10_miss_no_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != REG_ADDR) |=> ($past(flags) & ~flags) == '0);
endmodule

// File: tb/trig_fault_status_bench.sv
module trig_fault_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RA = 8'h08;
  localparam logic [7:0] OA = 8'h0C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        view_sticky = 1'b0;
  logic        clr_enable = 1'b0;
  logic [7:0]  trig_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_fault_status u_trig_fault_status (
    .clk(clk), .rst(rst), .view_sticky(view_sticky), .clr_enable(clr_enable),
    .trig_in(trig_in), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] t);
    trig_in = t; tick();
    trig_in = '0; tick();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    view_sticky = 1'b1;
    do_read(RA, v);
    chk("R1 flags after reset", v, 32'h0);
    view_sticky = 1'b0;
  endtask

  task automatic t_live();
    logic [31:0] v;
    trig_in = 8'hA5;
    do_read(RA, v);
    chk("R3 live A5 / R2 upper zero", v, 32'h0000_00A5);
    tick();
    chk("R11 idle after read", bus_rdata, 32'h0);
    trig_in = 8'h5A;
    do_read(RA, v);
    chk("R3 live 5A", v, 32'h0000_005A);
  endtask

  task automatic t_live_write();
    logic [31:0] v;
    clr_enable = 1'b1;
    do_write(RA, 32'hFFFF_FFFF);
    trig_in = '0; tick();
    view_sticky = 1'b1;
    do_read(RA, v);
    chk("R4/R9 history kept through live write", v, 32'h0000_00FF);
    do_write(RA, 32'h0000_00FF);
    do_read(RA, v);
    chk("R6 clear all", v, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    pulse(8'h11);
    do_read(RA, v);
    chk("R5 flags stay after fall", v, 32'h0000_0011);
    do_write(RA, 32'h0000_0001);
    do_read(RA, v);
    chk("R6 partial clear", v, 32'h0000_0010);
    do_write(RA, 32'h0000_0010);
    do_read(RA, v);
    chk("R6 second clear", v, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    pulse(8'h80);
    clr_enable = 1'b0;
    do_write(RA, 32'h0000_00FF);
    do_read(RA, v);
    chk("R7 gated write ignored", v, 32'h0000_0080);
    clr_enable = 1'b1;
    do_write(RA, 32'h0000_0080);
    do_read(RA, v);
    chk("R7 enabled write clears", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(8'h03);
    trig_in = 8'h01;
    do_write(RA, 32'h0000_0003);
    trig_in = '0; tick();
    do_read(RA, v);
    chk("R8 set beats clear", v, 32'h0000_0001);
    do_write(RA, 32'h0000_0001);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    pulse(8'h40);
    do_read(OA, v);
    chk("R10 other address reads zero", v, 32'h0);
    do_write(OA, 32'h0000_00FF);
    do_read(RA, v);
    chk("R10 other address write ignored", v, 32'h0000_0040);
    trig_in = 8'hFF;
    view_sticky = 1'b0;
    do_read(OA, v);
    chk("R10 other address live reads zero", v, 32'h0);
    trig_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_live();
    t_live_write();
    t_sticky();
    t_gate();
    t_collide();
    t_addr();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule